// File: doc/BRIEF.md
# Pipelined-to-Peripheral Bus Bridge

The block sits as a slave on a pipelined AHB-style system bus and turns each single transfer it accepts into one access on a simple APB-style peripheral bus. It is the only master on that bus. On the system side, address and control come one cycle ahead of their data. The bridge holds its ready output low for as long as the peripheral bus still owes the master something. On the peripheral side, every access is a fixed pair of cycles: a setup cycle, then an access cycle. One of fifteen select lines is raised, chosen from a four-bit field of the address.

Writes are posted. When the peripheral bus is free, the data phase of a write ends at once, and the captured data goes out in the next two cycles. A read holds the master until the access cycle is over, and the sampled word is then returned. A transfer that arrives while an access is running waits in a one-entry stage. It starts its setup cycle right after the running access cycle, with no idle cycle in between.

Top module: `apb_bridge`

## Requirements
- R1: After a synchronous reset, ready is 1, the response is OKAY (0), no select is raised, the strobe is 0 and read data is 0.
- R2: A transfer is taken only in a cycle where select is 1, ready is 1 and the transfer code is 2 (non-sequential) or 3 (sequential). Code 0 (idle) and code 1 (busy), or select at 0, start no peripheral access, write no peripheral and leave ready at 1.
- R3: Each peripheral access is one setup cycle (a select raised, strobe 0) followed by exactly one access cycle (strobe 1). The strobe is never high for two cycles in a row.
- R4: Peripheral address, write flag, select and (for writes) write data hold the same value in the access cycle as in the setup cycle.
- R5: Address bits [15:12] = k, for k from 0 to 14, raise select line k alone. The value 15 raises no select line.
- R6: A read taken while the peripheral bus is idle sees exactly 3 wait cycles. In the cycle ready returns to 1, read data holds the word the selected peripheral drove in the access cycle, or 0 when bits [15:12] are 15.
- R7: A write taken while the peripheral bus is idle ends its data phase with no wait cycle. The peripheral write data is the system write data of that data phase.
- R8: A transfer taken while an access is in progress waits in the bridge. Its setup cycle follows the running access cycle directly. Ready stays low until a pending write can be launched, or until a pending read has completed.
- R9: The response output is always OKAY (0).
- R10: After an access cycle with nothing pending, the peripheral bus goes idle: no select and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ahb_sel | input | 1 | Slave select from the system bus decoder |
| ahb_addr | input | AW | Address of the address phase |
| ahb_trans | input | 2 | Transfer code: 0 idle, 1 busy, 2 non-sequential, 3 sequential |
| ahb_write | input | 1 | 1 for write, 0 for read |
| ahb_wdata | input | DW | Write data of the data phase |
| ahb_ready | output | 1 | 0 inserts a wait cycle, 1 ends the data phase |
| ahb_resp | output | 1 | Transfer response, always OKAY (0) |
| ahb_rdata | output | DW | Read data, valid when a read data phase ends |
| per_addr | output | AW | Peripheral address |
| per_write | output | 1 | Peripheral write flag |
| per_wdata | output | DW | Peripheral write data |
| per_sel | output | NSEL | One select line per peripheral |
| per_strobe | output | 1 | High in the access cycle only |
| per_rdata | input | NSEL*DW | Read words of all peripherals, peripheral k in bits [k*DW +: DW] |

## Verification
The stimulus mixes several cases. An isolated write and an isolated read pin down the zero-wait and three-wait costs. Idle codes, busy codes and deselected transfers aimed at peripherals that are read back later show whether anything leaks onto the peripheral bus. Back-to-back writes to one peripheral force the access-to-setup step and the one-cycle stall, and a write followed at once by a read of the same peripheral checks that the posted data is seen. Accesses to field value 15 separate a missing select from a wrong one, and the same field returns zero on a read.

// File: rtl/apb_bridge_pkg.sv
package apb_bridge_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } apb_phase_e;

  localparam logic [1:0] TR_IDLE    = 2'b00;
  localparam logic [1:0] TR_BUSY    = 2'b01;
  localparam logic [1:0] TR_NONSEQ  = 2'b10;
  localparam logic [1:0] TR_SEQ     = 2'b11;
endpackage

// File: rtl/apb_bridge_sel_decode.sv
module apb_bridge_sel_decode #(
  parameter int NSEL  = 15,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] idx,
  output logic [NSEL-1:0]  sel_oh
);
  for (genvar i = 0; i < NSEL; i++) begin : g_line
    assign sel_oh[i] = (idx == SEL_W'(i));
  end
endmodule

// File: rtl/apb_bridge_rdata_mux.sv
module apb_bridge_rdata_mux #(
  parameter int NSEL  = 15,
  parameter int SEL_W = 4,
  parameter int DW    = 32
) (
  input  logic [SEL_W-1:0]   idx,
  input  logic [NSEL*DW-1:0] words,
  output logic [DW-1:0]      word
);
  always_comb begin
    word = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (idx == SEL_W'(i)) word = words[i*DW +: DW];
    end
  end
endmodule

// File: rtl/apb_bridge.sv
module apb_bridge
  import apb_bridge_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int NSEL    = 15,
  parameter int SEL_LSB = 12,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ahb_sel,
  input  logic [AW-1:0]      ahb_addr,
  input  logic [1:0]         ahb_trans,
  input  logic               ahb_write,
  input  logic [DW-1:0]      ahb_wdata,
  output logic               ahb_ready,
  output logic               ahb_resp,
  output logic [DW-1:0]      ahb_rdata,
  output logic [AW-1:0]      per_addr,
  output logic               per_write,
  output logic [DW-1:0]      per_wdata,
  output logic [NSEL-1:0]    per_sel,
  output logic               per_strobe,
  input  logic [NSEL*DW-1:0] per_rdata
);
  localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

  apb_phase_e          phase_q, phase_d;
  logic                dph_vld_q, dph_vld_d;
  logic                dph_wr_q, dph_wr_d;
  logic [AW-1:0]       dph_addr_q;
  logic [AW-1:0]       per_addr_q;
  logic                per_write_q;
  logic [DW-1:0]       per_wdata_q;
  logic [NSEL-1:0]     per_sel_q;
  logic                per_strobe_q;
  logic                ready_q, ready_d;
  logic [DW-1:0]       rdata_q;

  logic                accept, launch, op_wr_d, read_busy_d, pend_blocks, rd_done;
  logic [NSEL-1:0]     launch_sel;
  logic [DW-1:0]       mux_word;

  apb_bridge_sel_decode #(.NSEL(NSEL), .SEL_W(SEL_W)) u_dec (
    .idx    (dph_addr_q[SEL_MSB:SEL_LSB]),
    .sel_oh (launch_sel)
  );

  apb_bridge_rdata_mux #(.NSEL(NSEL), .SEL_W(SEL_W), .DW(DW)) u_mux (
    .idx   (per_addr_q[SEL_MSB:SEL_LSB]),
    .words (per_rdata),
    .word  (mux_word)
  );

  assign accept = ahb_sel && ready_q && (ahb_trans == TR_NONSEQ || ahb_trans == TR_SEQ);
  assign launch = dph_vld_q && (phase_q != PH_SETUP);
  assign rd_done = (phase_q == PH_ACCESS) && !per_write_q;

  always_comb begin
    unique case (phase_q)
      PH_SETUP:  phase_d = PH_ACCESS;
      default:   phase_d = launch ? PH_SETUP : PH_IDLE;
    endcase
  end

  always_comb begin
    op_wr_d     = launch ? dph_wr_q : per_write_q;
    dph_vld_d   = accept ? 1'b1 : (launch ? 1'b0 : dph_vld_q);
    dph_wr_d    = accept ? ahb_write : dph_wr_q;
    read_busy_d = (phase_d != PH_IDLE) && !op_wr_d;
    pend_blocks = dph_vld_d && !(dph_wr_d && (phase_d != PH_SETUP));
    ready_d     = !read_busy_d && !pend_blocks;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      dph_vld_q    <= 1'b0;
      dph_wr_q     <= 1'b0;
      dph_addr_q   <= '0;
      per_addr_q   <= '0;
      per_write_q  <= 1'b0;
      per_wdata_q  <= '0;
      per_sel_q    <= '0;
      per_strobe_q <= 1'b0;
      ready_q      <= 1'b1;
      rdata_q      <= '0;
    end else begin
      phase_q      <= phase_d;
      dph_vld_q    <= dph_vld_d;
      dph_wr_q     <= dph_wr_d;
      if (accept) dph_addr_q <= ahb_addr;
      if (launch) begin
        per_addr_q  <= dph_addr_q;
        per_write_q <= dph_wr_q;
        if (dph_wr_q) per_wdata_q <= ahb_wdata;
      end
      if (launch)                    per_sel_q <= launch_sel;
      else if (phase_d == PH_IDLE)   per_sel_q <= '0;
      per_strobe_q <= (phase_d == PH_ACCESS);
      ready_q      <= ready_d;
      if (rd_done) rdata_q <= mux_word;
    end
  end

  assign ahb_ready  = ready_q;
  assign ahb_resp   = 1'b0;
  assign ahb_rdata  = rdata_q;
  assign per_addr   = per_addr_q;
  assign per_write  = per_write_q;
  assign per_wdata  = per_wdata_q;
  assign per_sel    = per_sel_q;
  assign per_strobe = per_strobe_q;
endmodule

// File: rtl/apb_bridge_chk.sv
module apb_bridge_chk
  import apb_bridge_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NSEL = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            ahb_sel,
  input logic [1:0]      ahb_trans,
  input logic            ahb_ready,
  input logic [1:0]      phase,
  input logic [AW-1:0]   per_addr,
  input logic            per_write,
  input logic [DW-1:0]   per_wdata,
  input logic [NSEL-1:0] per_sel,
  input logic            per_strobe
);
  a_r3_setup_then_access: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SETUP) |=> (phase == PH_ACCESS));

  a_r3_access_follows_setup: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACCESS) |-> ($past(phase) == PH_SETUP));

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    per_strobe |=> !per_strobe);

  a_r4_hold_in_access: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACCESS) |-> ($stable(per_addr) && $stable(per_write) && $stable(per_sel)
                              && (!per_write || $stable(per_wdata))));

  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(per_sel));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (per_sel == '0 && !per_strobe));

  a_r2_ignored_keeps_ready: assert property (@(posedge clk) disable iff (rst)
    (ahb_ready && !(ahb_sel && ahb_trans[1])) |=> ahb_ready);

  a_r8_stall_starts_setup: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !ahb_ready) |=> (phase == PH_SETUP));
endmodule

bind apb_bridge apb_bridge_chk #(.AW(AW), .DW(DW), .NSEL(NSEL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ahb_sel    (ahb_sel),
  .ahb_trans  (ahb_trans),
  .ahb_ready  (ahb_ready),
  .phase      (phase_q),
  .per_addr   (per_addr),
  .per_write  (per_write),
  .per_wdata  (per_wdata),
  .per_sel    (per_sel),
  .per_strobe (per_strobe)
);

// File: tb/apb_bridge_bench.sv
module apb_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, NSEL = 15, SEL_LSB = 12, SEL_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ahb_sel = 1'b0, ahb_write = 1'b0;
  logic [1:0] ahb_trans = 2'b00;
  logic [AW-1:0] ahb_addr = '0;
  logic [DW-1:0] ahb_wdata = '0;
  logic ahb_ready, ahb_resp, per_write, per_strobe;
  logic [DW-1:0] ahb_rdata, per_wdata;
  logic [AW-1:0] per_addr;
  logic [NSEL-1:0] per_sel;
  logic [NSEL*DW-1:0] per_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_bridge #(.AW(AW), .DW(DW), .NSEL(NSEL), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) u_apb_bridge (
    .clk(clk), .rst(rst), .ahb_sel(ahb_sel), .ahb_addr(ahb_addr), .ahb_trans(ahb_trans),
    .ahb_write(ahb_write), .ahb_wdata(ahb_wdata), .ahb_ready(ahb_ready), .ahb_resp(ahb_resp),
    .ahb_rdata(ahb_rdata), .per_addr(per_addr), .per_write(per_write), .per_wdata(per_wdata),
    .per_sel(per_sel), .per_strobe(per_strobe), .per_rdata(per_rdata));

  int checks = 0, fails = 0;
  bit done = 1'b0, started = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // peripherals: one word register each
  logic [DW-1:0] pmem [NSEL];
  always_comb for (int i = 0; i < NSEL; i++) per_rdata[i*DW +: DW] = pmem[i];
  always @(posedge clk) begin
    for (int i = 0; i < NSEL; i++) begin
      if (rst) pmem[i] <= '0;
      else if (per_sel[i] && per_strobe && per_write) pmem[i] <= per_wdata;
    end
  end

  // behavioural reference
  typedef struct { logic [AW-1:0] a; bit w; } xfer_t;
  xfer_t m_q[$];
  int m_phase;
  logic [AW-1:0] m_addr;
  bit m_wr, m_ready, m_acc;
  logic [DW-1:0] m_wdata, m_rdata;
  logic [DW-1:0] m_mem [NSEL];
  int m_idx;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete(); m_phase = 0; m_addr = '0; m_wr = 0; m_ready = 1; m_wdata = '0; m_rdata = '0;
      for (int i = 0; i < NSEL; i++) m_mem[i] = '0;
    end else begin
      m_acc = ahb_sel && ahb_trans[1] && m_ready;
      m_idx = int'(m_addr[SEL_LSB +: SEL_W]);
      if (m_phase == 2) begin
        if (m_wr) begin
          if (m_idx < NSEL) m_mem[m_idx] = m_wdata;
        end else m_rdata = (m_idx < NSEL) ? m_mem[m_idx] : '0;
      end
      if (m_phase != 1 && m_q.size() > 0) begin
        m_addr = m_q[0].a; m_wr = m_q[0].w;
        if (m_wr) m_wdata = ahb_wdata;
        void'(m_q.pop_front());
        m_phase = 1;
      end else m_phase = (m_phase == 1) ? 2 : 0;
      if (m_acc) m_q.push_back('{a: ahb_addr, w: ahb_write});
      if (m_phase != 0 && !m_wr) m_ready = 0;
      else if (m_q.size() > 0) m_ready = m_q[0].w && (m_phase != 1);
      else m_ready = 1;
    end
  end

  int pulses = 0, b2b = 0;
  bit prev_strobe = 0;
  logic [NSEL-1:0] e_sel;
  int e_idx;
  always @(negedge clk) begin
    if (started && !done) begin
      e_idx = int'(m_addr[SEL_LSB +: SEL_W]);
      e_sel = (m_phase != 0 && e_idx < NSEL) ? (NSEL'(1) << e_idx) : '0;
      check(ahb_ready === m_ready, "R2 R6 R7 R8 ready", 64'(ahb_ready), 64'(m_ready));
      check(per_strobe === (m_phase == 2), "R3 strobe", 64'(per_strobe), 64'(m_phase == 2));
      check(per_sel === e_sel, "R5 R10 select", 64'(per_sel), 64'(e_sel));
      check(ahb_rdata === m_rdata, "R6 read data", 64'(ahb_rdata), 64'(m_rdata));
      check(ahb_resp === 1'b0, "R9 response", 64'(ahb_resp), 64'(0));
      if (m_phase != 0) begin
        check(per_addr === m_addr, "R4 address", 64'(per_addr), 64'(m_addr));
        check(per_write === m_wr, "R4 write flag", 64'(per_write), 64'(m_wr));
        if (m_wr) check(per_wdata === m_wdata, "R7 write data", 64'(per_wdata), 64'(m_wdata));
      end
      if (per_strobe && !prev_strobe) pulses++;
      if (prev_strobe && !per_strobe && per_sel != '0) b2b++;
      prev_strobe = per_strobe;
    end
  end

  // master stimulus
  typedef struct {
    bit sel; logic [1:0] trans; bit wr; logic [AW-1:0] addr; logic [DW-1:0] data;
    bit chk_rd; logic [DW-1:0] exp_rd; int exp_wait;
  } op_t;
  op_t ops[$];
  int waits[$];

  task automatic add(input bit s, input logic [1:0] t, input bit w, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input bit c, input logic [DW-1:0] e, input int ew);
    ops.push_back('{sel: s, trans: t, wr: w, addr: a, data: d, chk_rd: c, exp_rd: e, exp_wait: ew});
    waits.push_back(0);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int ptr, dph, n_real;
    add(1, 2'd0, 0, 32'h0,    32'h0,         0, 0, -1);
    add(1, 2'd2, 1, 32'h3004, 32'h1111_2222, 0, 0, 0);   // R7 isolated write
    add(1, 2'd0, 0, 32'h0,    32'h0,         0, 0, -1);
    add(1, 2'd0, 0, 32'h0,    32'h0,         0, 0, -1);
    add(1, 2'd0, 0, 32'h0,    32'h0,         0, 0, -1);
    add(1, 2'd2, 0, 32'h3004, 32'h0,         1, 32'h1111_2222, 3); // R6 isolated read
    add(1, 2'd1, 1, 32'h7000, 32'hDEAD_0001, 0, 0, -1);  // R2 busy code
    add(0, 2'd2, 1, 32'h6000, 32'hDEAD_0002, 0, 0, -1);  // R2 not selected
    add(1, 2'd2, 1, 32'h5008, 32'hAAAA_0005, 0, 0, 0);
    add(1, 2'd3, 1, 32'h500C, 32'hBBBB_0005, 0, 0, 1);   // R8 stalls one cycle
    add(1, 2'd2, 0, 32'hF000, 32'h0,         1, 32'h0, -1); // R5 R6 field 15
    add(1, 2'd3, 0, 32'h5000, 32'h0,         1, 32'hBBBB_0005, -1);
    add(1, 2'd2, 0, 32'h6000, 32'h0,         1, 32'h0, -1); // R2 untouched
    add(1, 2'd2, 0, 32'h7000, 32'h0,         1, 32'h0, -1); // R2 untouched
    add(1, 2'd2, 1, 32'h0010, 32'hCCCC_0000, 0, 0, -1);
    add(1, 2'd3, 0, 32'h0010, 32'h0,         1, 32'hCCCC_0000, -1);
    add(1, 2'd2, 1, 32'hE010, 32'hDDDD_000E, 0, 0, -1);
    add(1, 2'd3, 1, 32'hF004, 32'hEEEE_000F, 0, 0, -1);
    add(1, 2'd3, 0, 32'hE010, 32'h0,         1, 32'hDDDD_000E, -1);
    add(1, 2'd0, 0, 32'h0,    32'h0,         0, 0, -1);
    n_real = 0;
    foreach (ops[i]) if (ops[i].sel && ops[i].trans[1]) n_real++;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ahb_ready === 1'b1 && per_sel === '0 && per_strobe === 1'b0 && ahb_rdata === '0
          && ahb_resp === 1'b0, "R1 reset state",
          {ahb_ready, per_strobe, ahb_resp, 29'(per_sel), 32'(ahb_rdata)}, 64'h8000_0000_0000_0000);
    rst = 1'b0;
    started = 1'b1;

    ptr = 0; dph = -1;
    while (ptr < ops.size() || dph >= 0) begin
      if (ptr < ops.size()) begin
        ahb_sel = ops[ptr].sel; ahb_trans = ops[ptr].trans;
        ahb_write = ops[ptr].wr; ahb_addr = ops[ptr].addr;
      end else begin
        ahb_sel = 0; ahb_trans = 2'd0; ahb_write = 0; ahb_addr = '0;
      end
      ahb_wdata = (dph >= 0) ? ops[dph].data : '0;
      if (ahb_ready) begin
        if (dph >= 0) begin
          if (ops[dph].chk_rd)
            check(ahb_rdata === ops[dph].exp_rd, "R6 returned word", 64'(ahb_rdata), 64'(ops[dph].exp_rd));
          if (ops[dph].exp_wait >= 0)
            check(waits[dph] == ops[dph].exp_wait, "R6 R7 R8 wait cycles",
                  64'(waits[dph]), 64'(ops[dph].exp_wait));
        end
        dph = (ptr < ops.size() && ops[ptr].sel && ops[ptr].trans[1]) ? ptr : -1;
        if (ptr < ops.size()) ptr++;
      end else if (dph >= 0) waits[dph]++;
      @(negedge clk);
    end
    ahb_sel = 0; ahb_trans = 2'd0;
    repeat (8) @(negedge clk);
    check(pulses == n_real, "R2 R3 access count", 64'(pulses), 64'(n_real));
    check(b2b >= 1, "R8 access then setup", 64'(b2b), 64'(1));
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule